// File: doc/BRIEF.md
# Multi-format serial audio receiver

This block turns a three-wire serial audio stream into parallel stereo samples. The wires are a bit clock, a frame clock that marks which channel is on the line, and a data line. It runs in a system clock domain. It synchronises all three inputs and finds the rising edges of the bit clock. It keeps track of where each half-frame starts and pulls one fixed-width word out of every half-frame.

The format is chosen by a 2-bit select input. Three framings are supported: standard I2S, left-justified and right-justified. They differ in two ways: which frame-clock level marks the left channel, and where in the 32-bit half-frame the word sits. Right-justified words end on the last bit of the half-frame. The other two formats place the word at the front.

When a right-channel word completes after its left partner, both words appear together on the outputs with a one-cycle valid strobe. The block ignores the stream until it sees the first left half-frame start after reset. A new format selection takes effect only at a left half-frame start.

Top module: `sar_rx`

## Requirements
- R1: With select code 0 (I2S), a frame-clock level of 0 marks the left half-frame and 1 marks the right half-frame.
- R2: With select codes 1 (left-justified) and 2 (right-justified), a frame-clock level of 1 marks the left half-frame and 0 marks the right half-frame.
- R3: In I2S, the word MSB is the bit sampled on the second rising bit-clock edge of the half-frame (slot index 1). The word occupies slot indices 1 to 24, MSB first.
- R4: In left-justified format, the MSB is at slot index 0 (the first bit with the new frame-clock level). The word occupies slot indices 0 to 23.
- R5: In right-justified format, the word occupies slot indices 8 to 31 of a 32-bit half-frame, so its LSB is the last bit before the next frame-clock change.
- R6: Data bits at slot indices outside the word window have no effect on either output word.
- R7: `word_valid` is high for exactly one system-clock cycle per completed left/right pair. It is high in the cycle that follows the internal detection of the right word's LSB edge. The outputs change only with that pulse.
- R8: After reset, no pulse is produced until a complete frame has been received that begins at a left half-frame start. Any partial frame seen before that is discarded.
- R9: A change of the select input takes effect at the next left half-frame start, judged with the polarity of the new selection. A frame that is already in progress completes in the old format.
- R10: Select code 3 behaves exactly as code 0 (I2S).
- R11: While reset is asserted and after it is released, `word_valid`, `left_word` and `right_word` are 0 until the first pair is delivered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times faster than the bit clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sck | input | 1 | Serial bit clock, asynchronous |
| ws | input | 1 | Frame (channel) clock, changes while sck is low |
| sd | input | 1 | Serial data, changes while sck is low |
| fmt_sel | input | 2 | 0 I2S, 1 left-justified, 2 right-justified, 3 same as 0 |
| left_word | output | WORD_W (24) | Captured left sample |
| right_word | output | WORD_W (24) | Captured right sample |
| word_valid | output | 1 | One-cycle strobe: a new pair is on the outputs |

## Verification
A slot counter that is off by one appears at the ports as a word shifted by one bit, with one random junk bit at the MSB or the LSB. This is visible on the first delivered pair after the error. A wrong polarity or a wrong mode latch swaps the channels or misplaces the window for the whole frame, and it shows in that frame's pulse. A lost arming or left-pending flag appears as a missing or extra pulse, which the bench finds by comparing pulse counts at the end of each phase. Junk bits are always random, so any leak of out-of-window data corrupts the compared words within a frame or two.

// File: rtl/sar_pkg.sv
// Package for the serial audio receiver: format codes and helpers.
// Assumes the select input is two bits wide and code 3 is an alias of I2S.
package sar_pkg;

    typedef enum logic [1:0] {
        FMT_I2S = 2'd0,
        FMT_LJ  = 2'd1,
        FMT_RJ  = 2'd2,
        FMT_ALT = 2'd3
    } fmt_e;

    // Map the raw select code onto one of the three real formats.
    function automatic fmt_e fmt_norm(input logic [1:0] code);
        case (code)
            2'd1:    return FMT_LJ;
            2'd2:    return FMT_RJ;
            default: return FMT_I2S;
        endcase
    endfunction

    // Frame-clock level that marks the left half-frame in a format.
    function automatic logic left_level(input fmt_e f);
        return (f == FMT_I2S) ? 1'b0 : 1'b1;
    endfunction

endpackage

// File: rtl/sar_edge_sync.sv
// Synchroniser and edge finder for the three serial inputs.
// Runs the bit clock, frame clock and data through matched flop chains, so
// frame clock and data line up with the detected rising bit-clock edge.
// Assumes ws and sd are stable around rising sck and clk >= 8x sck.
module sar_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic ws_i,
    input  logic sd_i,
    output logic bit_stb,
    output logic ws_o,
    output logic sd_o
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] sck_p;
    logic [TOP:0] ws_p;
    logic [TOP:0] sd_p;
    logic         sck_d;

    // Shift each input through its synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sck_p <= '0;
            ws_p  <= '0;
            sd_p  <= '0;
            sck_d <= 1'b0;
        end else begin
            sck_p <= {sck_p[TOP-1:0], sck_i};
            ws_p  <= {ws_p[TOP-1:0], ws_i};
            sd_p  <= {sd_p[TOP-1:0], sd_i};
            sck_d <= sck_p[TOP];
        end
    end

    // One-cycle strobe on a synchronised rising bit-clock edge.
    always_comb begin
        bit_stb = sck_p[TOP] & ~sck_d;
        ws_o    = ws_p[TOP];
        sd_o    = sd_p[TOP];
    end

endmodule

// File: rtl/sar_frame_tracker.sv
// Frame tracker: finds frame-clock changes, counts slot indices inside each
// half-frame, latches the active format at left half-frame starts and
// marks which strobes carry word bits. All outputs are qualified by bit_stb.
// Assumes a half-frame of SLOT_W bit clocks, SLOT_W a power of two > WORD_W.
module sar_frame_tracker
    import sar_pkg::*;
#(
    parameter int WORD_W = 24,
    parameter int SLOT_W = 32
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bit_stb,
    input  logic       ws,
    input  logic [1:0] fmt_req,
    output logic       in_window,
    output logic       word_last,
    output logic       is_left,
    output logic       armed
);
    localparam int             CW      = $clog2(SLOT_W);
    localparam logic [CW-1:0]  IDX_MAX = CW'(SLOT_W - 1);
    localparam logic [CW-1:0]  OFF_I2S = CW'(1);
    localparam logic [CW-1:0]  OFF_LJ  = CW'(0);
    localparam logic [CW-1:0]  OFF_RJ  = CW'(SLOT_W - WORD_W);
    localparam logic [CW-1:0]  SPAN    = CW'(WORD_W - 1);

    logic          ws_prev;
    logic          seen;
    logic [CW-1:0] cnt;
    fmt_e          act_fmt;
    logic          armed_q;

    fmt_e          req_fmt;
    fmt_e          eff_fmt;
    logic          edge_hit;
    logic          lstart;
    logic [CW-1:0] idx;
    logic [CW-1:0] off;
    logic [CW-1:0] last;

    // Decode edges, the slot index and the window for the current strobe.
    always_comb begin
        req_fmt  = fmt_norm(fmt_req);
        edge_hit = bit_stb & seen & (ws != ws_prev);
        lstart   = edge_hit & (ws == left_level(req_fmt));
        eff_fmt  = lstart ? req_fmt : act_fmt;
        if (edge_hit)
            idx = '0;
        else if (cnt == IDX_MAX)
            idx = cnt;
        else
            idx = cnt + CW'(1);
        case (eff_fmt)
            FMT_LJ:  off = OFF_LJ;
            FMT_RJ:  off = OFF_RJ;
            default: off = OFF_I2S;
        endcase
        last      = off + SPAN;
        is_left   = (ws == left_level(eff_fmt));
        in_window = bit_stb & (armed_q | lstart) & (idx >= off) & (idx <= last);
        word_last = in_window & (idx == last);
        armed     = armed_q;
    end

    // Keep the previous frame-clock level, slot index, format and arming.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ws_prev <= 1'b0;
            seen    <= 1'b0;
            cnt     <= '0;
            act_fmt <= FMT_I2S;
            armed_q <= 1'b0;
        end else if (bit_stb) begin
            ws_prev <= ws;
            seen    <= 1'b1;
            cnt     <= idx;
            if (lstart) begin
                act_fmt <= req_fmt;
                armed_q <= 1'b1;
            end
        end
    end

    AST_FMT_ONLY_AT_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        !lstart |=> (act_fmt == $past(act_fmt))); // R9
    AST_ARM_NEEDS_LEFT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(armed_q) |-> $past(bit_stb && ws == left_level(fmt_norm(fmt_req)))); // R8

endmodule

// File: rtl/sar_word_shift.sv
// Word assembler: shifts window bits in MSB first, parks the finished left
// word and releases the pair with a one-cycle strobe at the right word's end.
// Assumes shift_en and word_last come from the frame tracker.
module sar_word_shift #(
    parameter int WORD_W = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              word_last,
    input  logic              is_left,
    input  logic              sd,
    output logic [WORD_W-1:0] left_o,
    output logic [WORD_W-1:0] right_o,
    output logic              valid_o
);
    logic [WORD_W-1:0] sh;
    logic [WORD_W-1:0] nxt;
    logic [WORD_W-1:0] left_hold;
    logic              left_ok;

    // Next shift value with the current data bit appended.
    always_comb nxt = {sh[WORD_W-2:0], sd};

    // Shift, park the left word, and publish the pair on the right LSB.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh        <= '0;
            left_hold <= '0;
            left_ok   <= 1'b0;
            left_o    <= '0;
            right_o   <= '0;
            valid_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (shift_en)
                sh <= nxt;
            if (word_last) begin
                if (is_left) begin
                    left_hold <= nxt;
                    left_ok   <= 1'b1;
                end else if (left_ok) begin
                    left_o  <= left_hold;
                    right_o <= nxt;
                    valid_o <= 1'b1;
                    left_ok <= 1'b0;
                end
            end
        end
    end

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_o |-> ($stable(left_o) && $stable(right_o))); // R7
    AST_PULSE_AFTER_RIGHT: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> $past(word_last && !is_left)); // R7

endmodule

// File: rtl/sar_rx.sv
// Top of the multi-format serial audio receiver. Chains the synchroniser,
// the frame tracker and the word assembler. All logic is on clk; sck, ws
// and sd are treated as asynchronous and oversampled.
module sar_rx #(
    parameter int WORD_W      = 24,
    parameter int SLOT_W      = 32,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sck,
    input  logic              ws,
    input  logic              sd,
    input  logic [1:0]        fmt_sel,
    output logic [WORD_W-1:0] left_word,
    output logic [WORD_W-1:0] right_word,
    output logic              word_valid
);
    logic bit_stb;
    logic ws_s;
    logic sd_s;
    logic in_window;
    logic word_last;
    logic is_left;
    logic armed;

    sar_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .sck_i   (sck),
        .ws_i    (ws),
        .sd_i    (sd),
        .bit_stb (bit_stb),
        .ws_o    (ws_s),
        .sd_o    (sd_s)
    );

    sar_frame_tracker #(.WORD_W(WORD_W), .SLOT_W(SLOT_W)) u_track (
        .clk       (clk),
        .rst_n     (rst_n),
        .bit_stb   (bit_stb),
        .ws        (ws_s),
        .fmt_req   (fmt_sel),
        .in_window (in_window),
        .word_last (word_last),
        .is_left   (is_left),
        .armed     (armed)
    );

    sar_word_shift #(.WORD_W(WORD_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .shift_en  (in_window),
        .word_last (word_last),
        .is_left   (is_left),
        .sd        (sd_s),
        .left_o    (left_word),
        .right_o   (right_word),
        .valid_o   (word_valid)
    );

    AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |=> !word_valid); // R7
    AST_VALID_ON_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(bit_stb)); // R7
    AST_VALID_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(armed)); // R8

endmodule

// File: tb/sar_rx_tb.sv
// Bench for sar_rx: a behavioural serializer sends frames in every format
// with random words and random junk outside the word window; a monitor
// compares each delivered pair against the queue of sent words.
module sar_rx_tb;
    localparam int W = 24;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sck = 1'b0;
    logic         ws = 1'b0;
    logic         sd = 1'b0;
    logic [1:0]   fmt_sel = 2'd0;
    logic [W-1:0] left_word;
    logic [W-1:0] right_word;
    logic         word_valid;

    int checks = 0;
    int errors = 0;
    int n_exp = 0;
    int n_got = 0;
    logic done = 1'b0;
    logic vprev = 1'b0;
    logic [W-1:0] exp_l [0:63];
    logic [W-1:0] exp_r [0:63];
    string        exp_tag [0:63];

    always #10 clk = ~clk;

    sar_rx u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .sck        (sck),
        .ws         (ws),
        .sd         (sd),
        .fmt_sel    (fmt_sel),
        .left_word  (left_word),
        .right_word (right_word),
        .word_valid (word_valid)
    );

    task automatic check(input string req, input logic ok, input logic [W-1:0] act, input logic [W-1:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%06h expected=%06h", req, act, expv);
        end
    endtask

    // Data bit for slot index i of a half-frame carrying word w in format m.
    function automatic logic bit_for(input logic [1:0] m, input int i, input logic [W-1:0] w);
        if (m == 2'd1) begin
            if (i < 24) return w[23-i];
        end else if (m == 2'd2) begin
            if (i >= 8) return w[31-i];
        end else begin
            if (i >= 1 && i <= 24) return w[24-i];
        end
        return 1'($urandom & 1);
    endfunction

    task automatic send_bit(input logic wv, input logic dv);
        @(negedge clk);
        ws = wv;
        sd = dv;
        repeat (4) @(negedge clk);
        sck = 1'b1;
        repeat (4) @(negedge clk);
        sck = 1'b0;
    endtask

    // One half-frame; optionally switch the select input at slot sw_at.
    task automatic send_half(input logic [1:0] m, input logic lvl, input logic [W-1:0] w,
                             input int sw_at, input logic [1:0] sw_mode);
        for (int i = 0; i < 32; i++) begin
            if (i == sw_at) fmt_sel = sw_mode;
            send_bit(lvl, bit_for(m, i, w));
        end
    endtask

    task automatic send_frame(input logic [1:0] m, input logic [W-1:0] l, input logic [W-1:0] r,
                              input string tag, input int sw_at, input logic [1:0] sw_mode);
        logic lv;
        lv = (m == 2'd1 || m == 2'd2) ? 1'b1 : 1'b0;
        exp_l[n_exp] = l;
        exp_r[n_exp] = r;
        exp_tag[n_exp] = tag;
        n_exp++;
        send_half(m, lv, l, sw_at, sw_mode);
        send_half(m, ~lv, r, 99, 2'd0);
    endtask

    task automatic send_filler(input logic lvl);
        for (int i = 0; i < 32; i++) send_bit(lvl, 1'($urandom & 1));
    endtask

    task automatic count_check(input string req);
        repeat (12) @(negedge clk);
        check(req, n_got == n_exp, W'(n_got), W'(n_exp));
    endtask

    // Monitor: compare each pulse with the queue, and check pulse width.
    always @(negedge clk) begin
        if (rst_n) begin
            if (word_valid && vprev)
                check("R7 pulse width", 1'b0, W'(1), W'(0));
            if (word_valid) begin
                if (n_got < n_exp) begin
                    check({exp_tag[n_got], " left"}, left_word == exp_l[n_got], left_word, exp_l[n_got]);
                    check({exp_tag[n_got], " right"}, right_word == exp_r[n_got], right_word, exp_r[n_got]);
                end else begin
                    check("R8 unexpected pulse", 1'b0, W'(n_got), W'(n_exp));
                end
                n_got++;
            end
        end
        vprev = word_valid;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R11: outputs are quiet during and right after reset.
        check("R11 valid in reset", word_valid == 1'b0, W'(word_valid), W'(0));
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check("R11 left after reset", left_word == '0, left_word, '0);
        check("R11 right after reset", right_word == '0, right_word, '0);
        check("R11 valid after reset", word_valid == 1'b0, W'(word_valid), W'(0));

        // R8: partial left tail then a full right half: nothing delivered.
        for (int i = 0; i < 12; i++) send_bit(1'b0, 1'($urandom & 1));
        send_filler(1'b1);
        count_check("R8 partial frame discarded");

        // R1, R3, R6: I2S with corner words and random words.
        send_frame(2'd0, 24'hFFFFFF, 24'h000000, "R1 R3 i2s ones/zeros", 99, 2'd0);
        send_frame(2'd0, 24'h800000, 24'h000001, "R3 i2s msb/lsb", 99, 2'd0);
        send_frame(2'd0, 24'h000001, 24'h800000, "R3 i2s lsb/msb", 99, 2'd0);
        for (int k = 0; k < 4; k++)
            send_frame(2'd0, W'($urandom), W'($urandom), "R1 R6 i2s random", 99, 2'd0);
        count_check("R7 i2s pulse count");

        // R10: code 3 behaves as I2S (same polarity, so no filler needed).
        fmt_sel = 2'd3;
        for (int k = 0; k < 2; k++)
            send_frame(2'd3, W'($urandom), W'($urandom), "R10 code3", 99, 2'd0);
        count_check("R10 pulse count");

        // R2, R4, R9: switch to left-justified; a filler half gives the edge.
        fmt_sel = 2'd1;
        send_filler(1'b1);
        send_filler(1'b0);
        send_frame(2'd1, 24'hFFFFFF, 24'h000001, "R2 R4 lj corner", 99, 2'd0);
        for (int k = 0; k < 3; k++)
            send_frame(2'd1, W'($urandom), W'($urandom), "R2 R4 R6 lj random", 99, 2'd0);
        count_check("R9 lj pulse count");

        // R9: select flips to right-justified mid-frame; frame stays LJ.
        send_frame(2'd1, W'($urandom), W'($urandom), "R9 mid-frame switch", 16, 2'd2);

        // R5: right-justified words aligned to the end of the half-frame.
        send_frame(2'd2, 24'h800001, 24'h7FFFFE, "R5 rj corner", 99, 2'd0);
        for (int k = 0; k < 3; k++)
            send_frame(2'd2, W'($urandom), W'($urandom), "R5 R6 rj random", 99, 2'd0);
        count_check("R5 rj pulse count");

        // R9: back to I2S via a filler half-frame.
        fmt_sel = 2'd0;
        send_filler(1'b1);
        for (int k = 0; k < 2; k++)
            send_frame(2'd0, W'($urandom), W'($urandom), "R9 back to i2s", 99, 2'd0);
        count_check("R9 final pulse count");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule